// File: doc/BRIEF.md
# Keyed-write oscillator control register file

This block is the APB register file of a ring-oscillator controller. Software writes 32-bit words to word-aligned offsets. Most control fields take effect only when the written word carries a specific key or code pattern. A word with any other pattern falls back to a defined safe setting, and it also sets a sticky bad-write flag. Software clears that flag by writing a one to it.

The outputs are decoded control levels for the analog part:

- an oscillator enable;
- a two-bit frequency range select;
- eight 3-bit drive-strength codes;
- a dormant request.

Status levels from the oscillator come back as inputs and are returned on status reads. Every implemented field reads back the raw value last written. Unmapped offsets complete without error and read as zero.

Register map (word offsets): 0x00 control, 0x04 drive strength A, 0x08 drive strength B, 0x0C seed, 0x10 dormant, 0x14 divider, 0x18 phase, 0x1C status, 0x20 random bit, 0x24 count.

Top module: `osc_ctrl_regs`

## Requirements
- R1: After reset the outputs are as follows: `osc_enable_o`=1, `range_sel_o`=0, `drive_o`=0 and `dormant_o`=0. Reads return the following values: control 0x00000aa0, seed 0x3f04b16d, dormant 0x77616b65, divider 0x0000aa20, phase 0x00000008. The status bad-write bit (bit 24) reads 0.
- R2: In a control write, bits 23:12 hold the enable code. Code 0xd1e drives `osc_enable_o` to 0. Code 0xfab, and every other code, drives it to 1.
- R3: In a control write, bits 11:0 hold the range code. The codes set `range_sel_o` as follows: 0xfa4 gives 0, 0xfa5 gives 1, 0xfa7 gives 2 and 0xfa6 gives 3. Any other range code leaves `range_sel_o` unchanged, and no write to another offset changes it.
- R4: Drive-strength register A (0x04) holds stage codes 0 to 3 at bits 2:0, 6:4, 10:8 and 14:12. Register B (0x08) holds stages 4 to 7 at the same positions. Stage n appears on `drive_o[3n+2:3n]` only while that register's bits 31:16 equal 0x9696. With any other key, that register's four stage codes output zero.
- R5: A dormant write (0x10) of 0x636f6d61 raises `dormant_o`. Any other 32-bit value, including 0x77616b65, clears it.
- R6: Status bit 24 (bad-write) is set by any of these writes:
  - a control write whose enable code is neither 0xd1e nor 0xfab, or whose range code is not one of the four valid codes;
  - a drive-strength write whose key is not 0x9696;
  - a divider write whose bits 15:8 differ from 0xaa, or whose bit 7 is set;
  - a phase write whose bits 11:4 differ from 0xaa;
  - a dormant write of any value other than the two codes.
- R7: Writing status with bit 24 set clears bad-write. With bit 24 clear, a status write leaves the flag as it is. Status bits 31, 16 and 12 read `stable_i`, `div_running_i` and `enabled_i`.
- R8: Reads return the raw value last written, masked as follows:
  - control: bits 23:0;
  - drive A: mask 0xffff77ff (the randomise bits 7 and 3 are kept);
  - drive B: mask 0xffff7777;
  - seed: all 32 bits;
  - dormant: all 32 bits;
  - divider: bits 15:0;
  - phase: bits 11:0;
  - count: bits 15:0.
  The random-bit offset reads `rand_bit_i` in bit 0.
- R9: `pready` is always 1 and `pslverr` is always 0. An access to an unmapped offset (0x28 and above) reads as zero and changes no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| stable_i | input | 1 | Oscillator stable status |
| div_running_i | input | 1 | Post-divider running status |
| enabled_i | input | 1 | Oscillator enabled status |
| rand_bit_i | input | 1 | Sampled oscillator output bit |
| osc_enable_o | output | 1 | Oscillator enable |
| range_sel_o | output | 2 | Range select (0 low, 1 medium, 2 high, 3 too high) |
| drive_o | output | 24 | Eight 3-bit drive-strength codes, stage 0 lowest |
| dormant_o | output | 1 | Dormant request |

## Verification
The bench builds the block with its default `ADDR_W` of 6. This leaves 16 word slots, of which 6 are unmapped, so the bench can exercise the zero-read and no-effect behaviour at both 0x28 and the top slot 0x3C. With that width, every key check, each fallback case and the set and clear paths of the sticky flag are reachable through ordinary APB writes.

// File: rtl/osc_ctrl_regs.sv
module osc_ctrl_regs #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              stable_i,
  input  logic              div_running_i,
  input  logic              enabled_i,
  input  logic              rand_bit_i,
  output logic              osc_enable_o,
  output logic [1:0]        range_sel_o,
  output logic [23:0]       drive_o,
  output logic              dormant_o
);
  localparam int NSTG = 8;
  localparam int DSW = 3;
  localparam int PER_REG = 4;
  localparam int IDX_W = ADDR_W - 2;

  localparam int R_CTRL = 0, R_DSA = 1, R_DSB = 2, R_SEED = 3, R_DORM = 4;
  localparam int R_DIV = 5, R_PH = 6, R_STAT = 7, R_RBIT = 8, R_CNT = 9;

  localparam logic [11:0] EN_OFF = 12'hd1e, EN_ON = 12'hfab;
  localparam logic [11:0] RG_LO = 12'hfa4, RG_MD = 12'hfa5, RG_HI = 12'hfa7, RG_TH = 12'hfa6;
  localparam logic [15:0] DS_KEY = 16'h9696;
  localparam logic [7:0]  DIV_KEY = 8'haa, PH_KEY = 8'haa;
  localparam logic [31:0] DORM_SLEEP = 32'h636f6d61, DORM_WAKE = 32'h77616b65;
  localparam logic [31:0] SEED_RST = 32'h3f04b16d;

  logic [IDX_W-1:0] idx;
  logic wr;
  logic we_ctrl, we_dsa, we_dsb, we_seed, we_dorm, we_div, we_ph, we_stat, we_cnt;
  logic [23:0] ctrl_q;
  logic [31:0] dsa_q, dsb_q, seed_q, dorm_q;
  logic [15:0] div_q, cnt_q;
  logic [11:0] ph_q;
  logic [1:0]  rng_q;
  logic        bad_q;
  logic        en_ok, rg_ok, bad_now;

  assign idx     = paddr[ADDR_W-1:2];
  assign wr      = psel & penable & pwrite;
  assign we_ctrl = wr && (int'(idx) == R_CTRL);
  assign we_dsa  = wr && (int'(idx) == R_DSA);
  assign we_dsb  = wr && (int'(idx) == R_DSB);
  assign we_seed = wr && (int'(idx) == R_SEED);
  assign we_dorm = wr && (int'(idx) == R_DORM);
  assign we_div  = wr && (int'(idx) == R_DIV);
  assign we_ph   = wr && (int'(idx) == R_PH);
  assign we_stat = wr && (int'(idx) == R_STAT);
  assign we_cnt  = wr && (int'(idx) == R_CNT);

  assign en_ok = (pwdata[23:12] == EN_OFF) || (pwdata[23:12] == EN_ON);
  assign rg_ok = (pwdata[11:0] == RG_LO) || (pwdata[11:0] == RG_MD) ||
                 (pwdata[11:0] == RG_HI) || (pwdata[11:0] == RG_TH);

  assign bad_now = (we_ctrl && !(en_ok && rg_ok)) ||
                   (we_dsa  && pwdata[31:16] != DS_KEY) ||
                   (we_dsb  && pwdata[31:16] != DS_KEY) ||
                   (we_div  && (pwdata[15:8] != DIV_KEY || pwdata[7])) ||
                   (we_ph   && pwdata[11:4] != PH_KEY) ||
                   (we_dorm && pwdata != DORM_SLEEP && pwdata != DORM_WAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 24'h000aa0;
      dsa_q  <= '0;
      dsb_q  <= '0;
      seed_q <= SEED_RST;
      dorm_q <= DORM_WAKE;
      div_q  <= {DIV_KEY, 8'd32};
      ph_q   <= 12'h008;
      cnt_q  <= '0;
      rng_q  <= 2'd0;
      bad_q  <= 1'b0;
    end else begin
      if (we_ctrl) ctrl_q <= pwdata[23:0];
      if (we_dsa)  dsa_q  <= pwdata & 32'hffff77ff;
      if (we_dsb)  dsb_q  <= pwdata & 32'hffff7777;
      if (we_seed) seed_q <= pwdata;
      if (we_dorm) dorm_q <= pwdata;
      if (we_div)  div_q  <= pwdata[15:0];
      if (we_ph)   ph_q   <= pwdata[11:0];
      if (we_cnt)  cnt_q  <= pwdata[15:0];
      if (we_ctrl) begin
        case (pwdata[11:0])
          RG_LO:   rng_q <= 2'd0;
          RG_MD:   rng_q <= 2'd1;
          RG_HI:   rng_q <= 2'd2;
          RG_TH:   rng_q <= 2'd3;
          default: rng_q <= rng_q;
        endcase
      end
      if (bad_now) bad_q <= 1'b1;
      else if (we_stat && pwdata[24]) bad_q <= 1'b0;
    end
  end

  assign osc_enable_o = ctrl_q[23:12] != EN_OFF;
  assign range_sel_o  = rng_q;
  assign dormant_o    = dorm_q == DORM_SLEEP;

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    localparam int LSB = (s % PER_REG) * 4;
    logic [31:0] src;
    assign src = (s < PER_REG) ? dsa_q : dsb_q;
    assign drive_o[s*DSW +: DSW] = (src[31:16] == DS_KEY) ? src[LSB +: DSW] : '0;
  end

  always_comb begin
    case (int'(idx))
      R_CTRL:  prdata = {8'h00, ctrl_q};
      R_DSA:   prdata = dsa_q;
      R_DSB:   prdata = dsb_q;
      R_SEED:  prdata = seed_q;
      R_DORM:  prdata = dorm_q;
      R_DIV:   prdata = {16'h0000, div_q};
      R_PH:    prdata = {20'h00000, ph_q};
      R_STAT:  prdata = {stable_i, 6'd0, bad_q, 7'd0, div_running_i, 3'd0, enabled_i, 12'd0};
      R_RBIT:  prdata = {31'd0, rand_bit_i};
      R_CNT:   prdata = {16'h0000, cnt_q};
      default: prdata = '0;
    endcase
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

// File: rtl/osc_ctrl_regs_chk.sv
module osc_ctrl_regs_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic              osc_enable_o,
  input logic [1:0]        range_sel_o,
  input logic [23:0]       drive_o,
  input logic              dormant_o,
  input logic              bad_q
);
  logic [ADDR_W-3:0] widx;
  logic              wr;
  assign widx = paddr[ADDR_W-1:2];
  assign wr   = psel & penable & pwrite;

  // R2
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(widx) == 0 && pwdata[23:12] == 12'hd1e) |=> !osc_enable_o);
  // R2
  en_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(widx) == 0 && pwdata[23:12] != 12'hd1e) |=> osc_enable_o);
  // R3
  range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && int'(widx) == 0) |=> $stable(range_sel_o));
  // R4
  ds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(widx) == 1 && pwdata[31:16] != 16'h9696) |=> drive_o[11:0] == 12'h000);
  // R5
  dormant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(widx) == 4) |=> dormant_o == ($past(pwdata) == 32'h636f6d61));
  // R6
  bad_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bad_q) |-> $past(wr));
  // R7
  bad_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(widx) == 7 && pwdata[24]) |=> !bad_q);
  // R9
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(widx) > 9) |=> $stable(drive_o) && $stable(osc_enable_o) &&
                               $stable(dormant_o) && $stable(bad_q));
endmodule

bind osc_ctrl_regs osc_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .osc_enable_o(osc_enable_o),
  .range_sel_o(range_sel_o), .drive_o(drive_o), .dormant_o(dormant_o),
  .bad_q(bad_q)
);

// File: tb/osc_ctrl_regs_tb_top.sv
module osc_ctrl_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic stable_i = 1'b1, div_running_i = 1'b0, enabled_i = 1'b1, rand_bit_i = 1'b1;
  logic osc_enable_o, dormant_o;
  logic [1:0] range_sel_o;
  logic [23:0] drive_o;
  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_ctrl_regs #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .stable_i(stable_i), .div_running_i(div_running_i),
    .enabled_i(enabled_i), .rand_bit_i(rand_bit_i), .osc_enable_o(osc_enable_o),
    .range_sel_o(range_sel_o), .drive_o(drive_o), .dormant_o(dormant_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic clr_bad();
    apb_wr(6'h1C, 32'h0100_0000);
  endtask

  task automatic bad_flag(output logic b);
    logic [31:0] s;
    apb_rd(6'h1C, s);
    b = s[24];
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 enable", {31'd0, osc_enable_o}, 32'd1);
    chk("R1 range", {30'd0, range_sel_o}, 32'd0);
    chk("R1 drive", {8'd0, drive_o}, 32'd0);
    chk("R1 dormant", {31'd0, dormant_o}, 32'd0);
    apb_rd(6'h00, d); chk("R1 ctrl read", d, 32'h00000aa0);
    apb_rd(6'h0C, d); chk("R1 seed read", d, 32'h3f04b16d);
    apb_rd(6'h10, d); chk("R1 dormant read", d, 32'h77616b65);
    apb_rd(6'h14, d); chk("R1 div read", d, 32'h0000aa20);
    apb_rd(6'h18, d); chk("R1 phase read", d, 32'h00000008);
    apb_rd(6'h1C, d); chk("R1 status read", d, 32'h80001000);
  endtask

  task automatic t_enable();
    apb_wr(6'h00, 32'h00d1efa4);
    chk("R2 disable code", {31'd0, osc_enable_o}, 32'd0);
    apb_wr(6'h00, 32'h00fabfa4);
    chk("R2 enable code", {31'd0, osc_enable_o}, 32'd1);
    apb_wr(6'h00, 32'h00d1efa4);
    apb_wr(6'h00, 32'h00123fa4);
    chk("R2 other code enables", {31'd0, osc_enable_o}, 32'd1);
    clr_bad();
  endtask

  task automatic t_range();
    apb_wr(6'h00, 32'h00fabfa5);
    chk("R3 medium", {30'd0, range_sel_o}, 32'd1);
    apb_wr(6'h00, 32'h00fabfa7);
    chk("R3 high", {30'd0, range_sel_o}, 32'd2);
    apb_wr(6'h00, 32'h00fabfa6);
    chk("R3 toohigh", {30'd0, range_sel_o}, 32'd3);
    apb_wr(6'h00, 32'h00fab123);
    chk("R3 invalid keeps", {30'd0, range_sel_o}, 32'd3);
    apb_wr(6'h04, 32'h96960fa4);
    chk("R3 other offset keeps", {30'd0, range_sel_o}, 32'd3);
    apb_wr(6'h00, 32'h00fabfa4);
    chk("R3 low", {30'd0, range_sel_o}, 32'd0);
    clr_bad();
  endtask

  task automatic t_drive();
    logic [31:0] d;
    logic b;
    apb_wr(6'h04, 32'h96965321);
    chk("R4 stages 0-3", {20'd0, drive_o[11:0]}, 32'h00000ad1);
    apb_wr(6'h08, 32'h96967654);
    chk("R4 stages 4-7", {20'd0, drive_o[23:12]}, 32'h00000fac);
    bad_flag(b); chk("R6 good key no flag", {31'd0, b}, 32'd0);
    apb_wr(6'h04, 32'h12345321);
    chk("R4 bad key zeroes A", {20'd0, drive_o[11:0]}, 32'd0);
    chk("R4 bad key leaves B", {20'd0, drive_o[23:12]}, 32'h00000fac);
    bad_flag(b); chk("R6 drive key flag", {31'd0, b}, 32'd1);
    apb_rd(6'h04, d); chk("R8 drive A raw", d, 32'h12345321);
    clr_bad();
    apb_wr(6'h04, 32'h969600ff);
    apb_rd(6'h04, d); chk("R8 drive A mask", d, 32'h969600ff);
    chk("R4 stage 0 ignores bit3", {29'd0, drive_o[2:0]}, 32'd7);
    apb_wr(6'h08, 32'h9696ffff);
    apb_rd(6'h08, d); chk("R8 drive B mask", d, 32'h96967777);
    apb_wr(6'h08, 32'h00007777);
    chk("R4 bad key zeroes B", {20'd0, drive_o[23:12]}, 32'd0);
    clr_bad();
  endtask

  task automatic t_dormant();
    logic b;
    apb_wr(6'h10, 32'h636f6d61);
    chk("R5 dormant set", {31'd0, dormant_o}, 32'd1);
    apb_wr(6'h10, 32'h77616b65);
    chk("R5 wake", {31'd0, dormant_o}, 32'd0);
    bad_flag(b); chk("R6 valid dormant no flag", {31'd0, b}, 32'd0);
    apb_wr(6'h10, 32'h636f6d61);
    apb_wr(6'h10, 32'h636f6d60);
    chk("R5 other value wakes", {31'd0, dormant_o}, 32'd0);
    bad_flag(b); chk("R6 dormant flag", {31'd0, b}, 32'd1);
    clr_bad();
  endtask

  task automatic t_badwrite();
    logic [31:0] d;
    logic b;
    apb_wr(6'h14, 32'h0000aa05);
    bad_flag(b); chk("R6 div good", {31'd0, b}, 32'd0);
    apb_wr(6'h14, 32'h0000aa85);
    bad_flag(b); chk("R6 div over 127", {31'd0, b}, 32'd1);
    clr_bad();
    apb_wr(6'h14, 32'h0000bb05);
    bad_flag(b); chk("R6 div key", {31'd0, b}, 32'd1);
    apb_rd(6'h14, d); chk("R8 div raw", d, 32'h0000bb05);
    clr_bad();
    apb_wr(6'h18, 32'h00000aa3);
    bad_flag(b); chk("R6 phase good", {31'd0, b}, 32'd0);
    apb_wr(6'h18, 32'h00000553);
    bad_flag(b); chk("R6 phase key", {31'd0, b}, 32'd1);
    apb_rd(6'h18, d); chk("R8 phase raw", d, 32'h00000553);
    clr_bad();
    apb_wr(6'h00, 32'h00fab555);
    bad_flag(b); chk("R6 range invalid", {31'd0, b}, 32'd1);
    clr_bad();
    apb_wr(6'h00, 32'h00777fa4);
    bad_flag(b); chk("R6 enable invalid", {31'd0, b}, 32'd1);
    clr_bad();
    apb_wr(6'h00, 32'h00fabfa4);
    apb_wr(6'h0C, 32'h12345678);
    apb_wr(6'h24, 32'h0000beef);
    bad_flag(b); chk("R6 valid writes no flag", {31'd0, b}, 32'd0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    apb_wr(6'h04, 32'h00000000);
    apb_wr(6'h1C, 32'h00000000);
    apb_rd(6'h1C, d); chk("R7 zero write keeps", d, 32'h81001000);
    apb_wr(6'h1C, 32'h01000000);
    apb_rd(6'h1C, d); chk("R7 clear", d, 32'h80001000);
    stable_i = 1'b0; div_running_i = 1'b1; enabled_i = 1'b0;
    apb_rd(6'h1C, d); chk("R7 status inputs", d, 32'h00010000);
    stable_i = 1'b1; div_running_i = 1'b0; enabled_i = 1'b1;
    rand_bit_i = 1'b0;
    apb_rd(6'h20, d); chk("R8 random bit 0", d, 32'd0);
    rand_bit_i = 1'b1;
    apb_rd(6'h20, d); chk("R8 random bit 1", d, 32'd1);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    apb_wr(6'h00, 32'hffd1efa7);
    apb_rd(6'h00, d); chk("R8 ctrl mask", d, 32'h00d1efa7);
    apb_rd(6'h0C, d); chk("R8 seed", d, 32'h12345678);
    apb_wr(6'h24, 32'hffff1234);
    apb_rd(6'h24, d); chk("R8 count mask", d, 32'h00001234);
    apb_wr(6'h00, 32'h00fabfa4);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    logic b;
    chk("R9 pready", {31'd0, pready}, 32'd1);
    chk("R9 pslverr", {31'd0, pslverr}, 32'd0);
    apb_wr(6'h28, 32'h00d1efa7);
    apb_wr(6'h3C, 32'h636f6d61);
    chk("R9 enable kept", {31'd0, osc_enable_o}, 32'd1);
    chk("R9 range kept", {30'd0, range_sel_o}, 32'd0);
    chk("R9 dormant kept", {31'd0, dormant_o}, 32'd0);
    apb_rd(6'h00, d); chk("R9 ctrl kept", d, 32'h00fabfa4);
    bad_flag(b); chk("R9 no flag", {31'd0, b}, 32'd0);
    apb_rd(6'h28, d); chk("R9 read 0x28", d, 32'd0);
    apb_rd(6'h3C, d); chk("R9 read 0x3C", d, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_range();
    t_drive();
    t_dormant();
    t_badwrite();
    t_status();
    t_readback();
    t_unmapped();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule